// File: doc/BRIEF.md
# General-Purpose I/O Bank with Set/Clear Configuration

This block controls one bank of up to 32 general-purpose pins. Every pin is either owned by the GPIO logic itself or handed to one of two on-chip peripheral functions, called function A and function B. Software changes configuration through a small word-addressed register port. Each attribute of a pin has three addresses: one where a 1 sets the pin's attribute, one where a 1 clears it, and one that reads the attribute back. Because of this, one pin can be changed without a read-modify-write, and other pins cannot be disturbed by mistake.

Seven attributes are held per pin:
- GPIO ownership
- output enable
- output level
- pull-up
- input filter
- open-drain
- function-B select

For each pin the block drives the pad's output value, output enable and pull-up control. The pad level passes through a synchronizer, and optionally through a glitch filter. The result is readable at all times, whoever owns the pin, and is also given to the peripherals.

Top module: `gpio_bank`

## Requirements
- R1: Register address layout: `reg_addr[4:2]` selects the attribute (0 ownership, 1 output enable, 2 output level, 3 pull-up, 4 filter, 5 open-drain, 6 function-B select, 7 pin data). `reg_addr[1:0]` selects the access (0 set, 1 clear, 2 status). A write to a set address sets every pin whose bit in `reg_wdata` is 1, and leaves pins whose bit is 0 unchanged.
- R2: A write to a clear address clears every pin whose bit in `reg_wdata` is 1, and leaves the other pins unchanged.
- R3: `reg_rdata` is combinational on `reg_addr`. A status address returns the attribute, and a write becomes visible there after the write clock edge. Set addresses, clear addresses and access code 3 read as 0.
- R4: After reset, every pin is owned by GPIO, has output disabled, output level 0, pull-up on, filter off, open-drain off and function A selected.
- R5: On a GPIO-owned pin that is not open-drain, `pad_oe` follows output enable and `pad_out` follows the output level. The level may be written while the output is disabled, and it appears unchanged on the pad once the output is enabled.
- R6: On a pin not owned by GPIO, `pad_out` and `pad_oe` come from function B when the pin's select bit is 1, and from function A when it is 0.
- R7: On an open-drain pin, `pad_out` is 0. `pad_oe` is 1 only when the selected driver enables its output and wants a low level; otherwise the pad is released.
- R8: `pad_pu` equals the pull-up status of each pin.
- R9: Pin data (attribute 7, status) shows `pad_in` after a two-flop synchronizer. A change at the pad is readable two clock edges later, and not after one, whatever the pin's owner.
- R10: When a pin's filter is on, its pin data changes only after the synchronized level has held for `FILT_DEPTH` (default 3) consecutive cycles. A one-cycle pulse never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | NUM_PINS | Write data, one bit per pin |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | NUM_PINS | Read data |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pu | output | NUM_PINS | Pad pull-up enables |
| fa_out | input | NUM_PINS | Function A output values |
| fa_oe | input | NUM_PINS | Function A output enables |
| fb_out | input | NUM_PINS | Function B output values |
| fb_oe | input | NUM_PINS | Function B output enables |
| core_pin_in | output | NUM_PINS | Conditioned pin levels for peripherals |

## Verification
The bench writes set and clear masks that overlap bits already set. This shows whether a 0 bit disturbs a pin: a design that wrote the whole word would lose them. It programs the output level before the output enable, and then mixes GPIO pins, function-A pins and function-B pins in one word. A wrong mux select, or a mux that ignores ownership, shows up on single pins. Open-drain is checked both with a high level and with a low level, which catches a pad driven high. Pin data is sampled exactly one and two edges after a pad change, which exposes a synchronizer that is missing a stage or has one too many. A one-cycle pulse with the filter on catches a filter that does nothing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int ATTR_W   = 3;
   localparam int ACC_W    = 2;
   localparam int ADDR_W   = ATTR_W + ACC_W;
   localparam int NUM_CFG  = 7;

   typedef enum logic [ATTR_W-1:0] {
      AT_OWN  = 3'd0,
      AT_OE   = 3'd1,
      AT_LVL  = 3'd2,
      AT_PULL = 3'd3,
      AT_FILT = 3'd4,
      AT_ODRN = 3'd5,
      AT_SELB = 3'd6,
      AT_PIN  = 3'd7
   } attr_e;

   typedef enum logic [ACC_W-1:0] {
      AC_SET  = 2'd0,
      AC_CLR  = 2'd1,
      AC_STAT = 2'd2,
      AC_RSV  = 2'd3
   } acc_e;

   // attributes whose reset state is all ones
   function automatic bit cfg_resets_high(int idx);
      return (idx == int'(AT_OWN)) || (idx == int'(AT_PULL));
   endfunction

endpackage

// File: rtl/gpio_sc_reg.sv
// One configuration vector changed only by set and clear strobes.
module gpio_sc_reg #(
   parameter int W         = 32,
   parameter bit RST_HIGH  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] RST_VAL = RST_HIGH ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (set_en) nxt = nxt | mask;
      if (clr_en) nxt = nxt & ~mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

endmodule

// File: rtl/gpio_in_cond.sv
// Pad input synchronizer plus an optional per-pin glitch filter.
module gpio_in_cond #(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH  = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad_in,
   input  logic [W-1:0] filt_en,
   output logic [W-1:0] sync_lvl,
   output logic [W-1:0] pin_lvl
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_in_cond: SYNC_STAGES must be at least 2");
   end
   if (FILT_DEPTH < 1) begin : g_bad_filt
      $error("gpio_in_cond: FILT_DEPTH must be at least 1");
   end

   logic [W-1:0] stage_q [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= pad_in;
         for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_lvl = stage_q[SYNC_STAGES-1];

   if (FILT_DEPTH > 1) begin : g_filter
      localparam int HIST = FILT_DEPTH - 1;

      logic [W-1:0] hist_q [HIST];
      logic [W-1:0] held_q;
      logic [W-1:0] all_hi;
      logic [W-1:0] all_lo;

      always_comb begin
         all_hi = sync_lvl;
         all_lo = ~sync_lvl;
         for (int h = 0; h < HIST; h++) begin
            all_hi = all_hi & hist_q[h];
            all_lo = all_lo & ~hist_q[h];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int h = 0; h < HIST; h++) hist_q[h] <= '0;
            held_q <= '0;
         end else begin
            hist_q[0] <= sync_lvl;
            for (int h = 1; h < HIST; h++) hist_q[h] <= hist_q[h-1];
            held_q <= (held_q & ~all_lo) | all_hi;
         end
      end

      assign pin_lvl = (filt_en & held_q) | (~filt_en & sync_lvl);
   end else begin : g_nofilter
      logic [W-1:0] unused_en;
      assign unused_en = filt_en;
      assign pin_lvl   = sync_lvl;
   end

endmodule

// File: rtl/gpio_pad_mux.sv
// Per-pin selection of the pad driver and open-drain conversion.
module gpio_pad_mux #(
   parameter int W = 32
) (
   input  logic [W-1:0] own,
   input  logic [W-1:0] selb,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] oe,
   input  logic [W-1:0] odrn,
   input  logic [W-1:0] fa_out,
   input  logic [W-1:0] fa_oe,
   input  logic [W-1:0] fb_out,
   input  logic [W-1:0] fb_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe
);

   for (genvar p = 0; p < W; p++) begin : g_pin
      logic drv_v;
      logic drv_e;

      always_comb begin
         if (own[p]) begin
            drv_v = lvl[p];
            drv_e = oe[p];
         end else if (selb[p]) begin
            drv_v = fb_out[p];
            drv_e = fb_oe[p];
         end else begin
            drv_v = fa_out[p];
            drv_e = fa_oe[p];
         end
      end

      always_comb begin
         if (odrn[p]) begin
            pad_out[p] = 1'b0;
            pad_oe[p]  = drv_e & ~drv_v;
         end else begin
            pad_out[p] = drv_v;
            pad_oe[p]  = drv_e;
         end
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [NUM_PINS-1:0] reg_wdata,
   input  logic                reg_we,
   output logic [NUM_PINS-1:0] reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   input  logic [NUM_PINS-1:0] fa_out,
   input  logic [NUM_PINS-1:0] fa_oe,
   input  logic [NUM_PINS-1:0] fb_out,
   input  logic [NUM_PINS-1:0] fb_oe,
   output logic [NUM_PINS-1:0] core_pin_in
);

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_width
      $error("gpio_bank: NUM_PINS must lie in 1..32");
   end

   attr_e acc_attr;
   acc_e  acc_kind;

   assign acc_attr = attr_e'(reg_addr[ADDR_W-1:ACC_W]);
   assign acc_kind = acc_e'(reg_addr[ACC_W-1:0]);

   logic [NUM_PINS-1:0] cfg_q [NUM_CFG];

   for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
      logic hit;
      assign hit = reg_we && (int'(acc_attr) == k);

      gpio_sc_reg #(
         .W        (NUM_PINS),
         .RST_HIGH (cfg_resets_high(k))
      ) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (hit && (acc_kind == AC_SET)),
         .clr_en (hit && (acc_kind == AC_CLR)),
         .mask   (reg_wdata),
         .q      (cfg_q[k])
      );
   end

   logic [NUM_PINS-1:0] own_q, oe_q, lvl_q, pull_q, filt_q, odrn_q, selb_q;

   assign own_q  = cfg_q[int'(AT_OWN)];
   assign oe_q   = cfg_q[int'(AT_OE)];
   assign lvl_q  = cfg_q[int'(AT_LVL)];
   assign pull_q = cfg_q[int'(AT_PULL)];
   assign filt_q = cfg_q[int'(AT_FILT)];
   assign odrn_q = cfg_q[int'(AT_ODRN)];
   assign selb_q = cfg_q[int'(AT_SELB)];

   logic [NUM_PINS-1:0] sync_lvl;
   logic [NUM_PINS-1:0] pin_lvl;

   gpio_in_cond #(
      .W           (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_DEPTH  (FILT_DEPTH)
   ) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .filt_en  (filt_q),
      .sync_lvl (sync_lvl),
      .pin_lvl  (pin_lvl)
   );

   gpio_pad_mux #(
      .W (NUM_PINS)
   ) u_mux (
      .own     (own_q),
      .selb    (selb_q),
      .lvl     (lvl_q),
      .oe      (oe_q),
      .odrn    (odrn_q),
      .fa_out  (fa_out),
      .fa_oe   (fa_oe),
      .fb_out  (fb_out),
      .fb_oe   (fb_oe),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   assign pad_pu      = pull_q;
   assign core_pin_in = pin_lvl;

   always_comb begin
      reg_rdata = '0;
      if (acc_kind == AC_STAT) begin
         if (acc_attr == AT_PIN) reg_rdata = pin_lvl;
         else                    reg_rdata = cfg_q[int'(acc_attr)];
      end
   end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [NUM_PINS-1:0] reg_wdata,
   input logic                reg_we,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] own_q,
   input logic [NUM_PINS-1:0] oe_q,
   input logic [NUM_PINS-1:0] pull_q,
   input logic [NUM_PINS-1:0] odrn_q,
   input logic [NUM_PINS-1:0] sync_lvl
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1
   oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == {AT_OE, AC_SET}) |=>
         (oe_q == ($past(oe_q) | $past(reg_wdata))));

   // R2
   oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == {AT_OE, AC_CLR}) |=>
         (oe_q == ($past(oe_q) & ~$past(reg_wdata))));

   // R4
   rst_state_chk: assert property (@(posedge clk)
      !rst_n |-> (own_q == '1 && oe_q == '0 && pull_q == '1 && odrn_q == '0));

   // R5
   gpio_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((own_q & ~odrn_q & (pad_oe ^ oe_q)) == '0));

   // R7
   odrn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & odrn_q) == '0));

   if (SYNC_STAGES == 2) begin : g_sync
      // R9
      sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2) |-> (sync_lvl == $past(pad_in, 2)));
   end

endmodule

bind gpio_bank gpio_bank_chk #(
   .NUM_PINS    (NUM_PINS),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_we    (reg_we),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .own_q     (own_q),
   .oe_q      (oe_q),
   .pull_q    (pull_q),
   .odrn_q    (odrn_q),
   .sync_lvl  (sync_lvl)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 32;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [4:0]    reg_addr = '0;
   logic [NP-1:0] reg_wdata = '0;
   logic          reg_we = 1'b0;
   logic [NP-1:0] reg_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pad_pu;
   logic [NP-1:0] fa_out = '0, fa_oe = '0, fb_out = '0, fb_oe = '0;
   logic [NP-1:0] core_pin_in;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .fa_out(fa_out), .fa_oe(fa_oe), .fb_out(fb_out), .fb_oe(fb_oe),
      .core_pin_in(core_pin_in)
   );

   // kinds: 0 read data, 1 pad_out, 2 pad_oe, 3 pad_pu
   typedef struct {
      int            kind;
      logic [NP-1:0] exp;
      string         tag;
   } item_t;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;

   // shadow configuration: 0 own,1 oe,2 lvl,3 pull,4 filt,5 odrn,6 selb
   logic [NP-1:0] sh [7];

   function automatic logic [4:0] adr(int attr, int acc);
      return {attr[2:0], acc[1:0]};
   endfunction

   function automatic logic [NP-1:0] exp_pad(bit want_oe);
      logic [NP-1:0] r;
      for (int i = 0; i < NP; i++) begin
         logic v, e;
         if (sh[0][i])      begin v = sh[2][i]; e = sh[1][i]; end
         else if (sh[6][i]) begin v = fb_out[i]; e = fb_oe[i]; end
         else               begin v = fa_out[i]; e = fa_oe[i]; end
         if (sh[5][i]) r[i] = want_oe ? (e & ~v) : 1'b0;
         else          r[i] = want_oe ? e : v;
      end
      return r;
   endfunction

   task automatic wr(int attr, int acc, logic [NP-1:0] d);
      @(negedge clk);
      reg_addr = adr(attr, acc); reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      if (acc == 0) sh[attr] = sh[attr] | d;
      if (acc == 1) sh[attr] = sh[attr] & ~d;
   endtask

   task automatic chk_rd(logic [4:0] a, logic [NP-1:0] e, string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a;
      #1;
      it.kind = 0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic chk_pads(string tag);
      item_t it;
      @(negedge clk);
      #1;
      it.tag = tag;
      it.kind = 1; it.exp = exp_pad(1'b0); sb_q.push_back(it);
      it.kind = 2; it.exp = exp_pad(1'b1); sb_q.push_back(it);
      it.kind = 3; it.exp = sh[3];         sb_q.push_back(it);
   endtask

   task automatic drive_pad(logic [NP-1:0] v);
      @(negedge clk);
      pad_in = v;
   endtask

   // monitor: compares queued expectations away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [NP-1:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               1:       act = pad_out;
               2:       act = pad_oe;
               3:       act = pad_pu;
               default: act = reg_rdata;
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_err++;
               $display("FAIL %s kind=%0d actual=%h expected=%h",
                        it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] v;
      sh[0] = '1; sh[1] = '0; sh[2] = '0; sh[3] = '1;
      sh[4] = '0; sh[5] = '0; sh[6] = '0;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4 reset state
      chk_rd(adr(0, 2), '1, "R4 own");
      chk_rd(adr(1, 2), '0, "R4 oe");
      chk_rd(adr(2, 2), '0, "R4 lvl");
      chk_rd(adr(3, 2), '1, "R4 pull");
      chk_rd(adr(4, 2), '0, "R4 filt");
      chk_rd(adr(5, 2), '0, "R4 odrn");
      chk_rd(adr(6, 2), '0, "R4 selb");
      chk_pads("R4 pads");

      // R1 set with overlapping masks
      wr(1, 0, 32'h0000_00F0);
      chk_rd(adr(1, 2), 32'h0000_00F0, "R1 oe first");
      wr(1, 0, 32'h0F00_0010);
      chk_rd(adr(1, 2), 32'h0F00_00F0, "R1 oe keep");

      // R2 clear
      wr(1, 1, 32'h0000_0030);
      chk_rd(adr(1, 2), 32'h0F00_00C0, "R2 oe clear");
      wr(3, 1, 32'hFFFF_0000);
      chk_rd(adr(3, 2), 32'h0000_FFFF, "R2 pull clear");
      // R8 pull-up pins
      chk_pads("R8 pull pads");

      // R3 non-status reads
      chk_rd(adr(1, 0), '0, "R3 set reads 0");
      chk_rd(adr(1, 1), '0, "R3 clr reads 0");
      chk_rd(adr(1, 3), '0, "R3 rsv reads 0");

      // R5 level preset before output enable
      wr(2, 0, 32'h0000_0001);
      chk_pads("R5 preset");
      wr(1, 0, 32'h0000_0001);
      chk_pads("R5 enabled");

      // R6 peripheral ownership
      fa_out = 32'hAAAA_5555; fa_oe = 32'h0F0F_00FF;
      fb_out = 32'h1234_5678; fb_oe = 32'hFFFF_0000;
      wr(0, 1, 32'hFF00_0000);
      wr(6, 0, 32'hF000_0000);
      chk_pads("R6 mixed");
      chk_rd(adr(0, 2), 32'h00FF_FFFF, "R6 own status");

      // R7 open-drain: pin0 high+oe, pin1 low+oe, pin 28-31 from function B
      wr(1, 0, 32'h0000_0002);
      wr(5, 0, 32'hF000_0003);
      chk_pads("R7 open drain");

      // R9 synchronizer latency, all owners
      v = 32'h5A5A_0F0F;
      drive_pad(v);
      chk_rd(adr(7, 2), '0, "R9 one edge");
      chk_rd(adr(7, 2), v, "R9 two edges");

      // R10 filter rejects a one-cycle pulse
      wr(4, 0, '1);
      repeat (8) @(negedge clk);
      chk_rd(adr(7, 2), v, "R10 settled");
      drive_pad(v ^ 32'h0000_0001);
      drive_pad(v);
      for (int k = 0; k < 6; k++) chk_rd(adr(7, 2), v, "R10 pulse hidden");
      drive_pad(v ^ 32'h0000_00FF);
      repeat (8) @(negedge clk);
      chk_rd(adr(7, 2), v ^ 32'h0000_00FF, "R10 level accepted");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule